// File: doc/BRIEF.md
# Byte-Wide Multi-Cycle Processor with Word Register Pairs

This block is a small multi-cycle processor built around an 8-bit data path. It holds two byte registers, A and B, and two 16-bit word registers, C and D. It fetches one-byte opcodes, plus any two-byte operand, from an internal byte memory. Byte arithmetic returns a 16-bit result to the {B,A} pair, with the upper byte in B. Word arithmetic returns a 32-bit result to {D,C}. Transfer instructions move the {B,A} pair into or out of the word registers. Branches test carry, zero or register equality. There is one byte-wide input port and one registered byte-wide output port.

The program is written into memory through a load port that is accepted only while reset is held high. Once reset is released, execution starts at address 0 and continues until a halt instruction. The halt flag is visible at the ports. Memory depth is a parameter, and every 16-bit address is reduced to its low address bits.

Top module: `regpair_cpu`

## Requirements
- R1: While `rst` is high (sampled at a clock edge), the processor clears the program counter, A, B, C, D, the output port and the halt flag. The load port writes `ld_data` to `ld_addr` only during those cycles.
- R2: LDA (0x02) and LDB (0x03) load A or B from memory, and STR (0x08) writes A to memory. The address is {second operand byte, first operand byte}.
- R3: Byte arithmetic writes its 16-bit result to {B,A}. The opcodes are 0x09 add, 0x0A subtract (two's complement), 0x0B multiply and 0x0C divide. Divide leaves B = 0.
- R4: Byte logic writes only A and leaves B unchanged. The opcodes are 0x0D AND, 0x0E OR, 0x0F XOR and 0x10 bitwise complement of A.
- R5: Word arithmetic on C and D writes its 32-bit result to {D,C}. The opcodes are 0x11 add, 0x12 subtract, 0x13 multiply and 0x14 divide. Word logic writes only C. Its opcodes are 0x15 AND, 0x16 OR, 0x17 XOR and 0x18 complement.
- R6: The transfer opcodes are as follows. 0x04 sets C to {B,A}, and 0x05 sets D to {B,A}. 0x06 sets {B,A} to C, and 0x07 sets {B,A} to D. 0x20 swaps A and B, and 0x21 swaps C and D.
- R7: Division by zero returns all ones over the full result: {B,A} = 0xFFFF for bytes, and {D,C} = 0xFFFFFFFF for words.
- R8: JMP (0x1B) sets the program counter to {first operand byte, second operand byte}.
- R9: The conditional jumps take the same operands. 0x1C jumps when A+B > 255, 0x1D when A == 0, 0x1E when A == B, and 0x1F when C == D. When the jump is not taken, execution continues after the operand bytes.
- R10: Cycle costs from fetch to next fetch are as follows. A NOP (0x00) or any opcode above 0x21 takes 5 cycles. An opcode without operands takes 2 cycles, and an opcode with operands takes 4. HLT (0x01) raises `halted` at the end of its second cycle.
- R11: Once `halted` is high, it stays high and `out_port` stays constant until reset.
- R12: IN (0x19) copies `in_port` into A, and OUT (0x1A) copies A into `out_port`.
- R13: The program counter wraps modulo the memory depth. The address bits above the memory's address width are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| ld_en | input | 1 | Load-port write strobe |
| ld_addr | input | AW | Load-port byte address |
| ld_data | input | 8 | Load-port byte |
| in_port | input | 8 | Byte input port |
| out_port | output | 8 | Registered byte output port |
| halted | output | 1 | Halt flag |

## Verification
Two things land in the same execute cycle: the register pair that supplies an operation's operands is also overwritten with that operation's result. So a word operation writes D from the high half of a product or difference, even though D was one of its inputs. The bench provokes this case in sweeps over operand grids that include zero, one, the sign boundaries and all ones. Each byte of the result is read back through transfers and the output port, and compared with arithmetic computed in the bench. Reset also coincides with load-port writes: the bench checks the cleared outputs while the program is being written, and then checks the program's results.

// File: rtl/regpair_cpu_pkg.sv
package regpair_cpu_pkg;

    typedef enum logic [2:0] {
        ST_FETCH = 3'd0,
        ST_OPA   = 3'd1,
        ST_OPB   = 3'd2,
        ST_EXEC  = 3'd3,
        ST_WAIT  = 3'd4,
        ST_HALT  = 3'd5
    } cpu_state_e;

    localparam logic [7:0] OPC_NOP   = 8'h00;
    localparam logic [7:0] OPC_HLT   = 8'h01;
    localparam logic [7:0] OPC_LDA   = 8'h02;
    localparam logic [7:0] OPC_LDB   = 8'h03;
    localparam logic [7:0] OPC_A2C   = 8'h04;
    localparam logic [7:0] OPC_A2D   = 8'h05;
    localparam logic [7:0] OPC_C2A   = 8'h06;
    localparam logic [7:0] OPC_D2A   = 8'h07;
    localparam logic [7:0] OPC_STR   = 8'h08;
    localparam logic [7:0] OPC_B_LO  = 8'h09;
    localparam logic [7:0] OPC_B_HI  = 8'h10;
    localparam logic [7:0] OPC_W_LO  = 8'h11;
    localparam logic [7:0] OPC_W_HI  = 8'h18;
    localparam logic [7:0] OPC_IN    = 8'h19;
    localparam logic [7:0] OPC_OUT   = 8'h1A;
    localparam logic [7:0] OPC_JMP   = 8'h1B;
    localparam logic [7:0] OPC_JC_LO = 8'h1C;
    localparam logic [7:0] OPC_JC_HI = 8'h1F;
    localparam logic [7:0] OPC_SWB   = 8'h20;
    localparam logic [7:0] OPC_SWW   = 8'h21;

    function automatic logic takes_operands(input logic [7:0] opc);
        return (opc == OPC_LDA) || (opc == OPC_LDB) || (opc == OPC_STR) ||
               ((opc >= OPC_JMP) && (opc <= OPC_JC_HI));
    endfunction

    function automatic logic is_plain_op(input logic [7:0] opc);
        return (opc != OPC_NOP) && (opc <= OPC_SWW) && !takes_operands(opc);
    endfunction

endpackage

// File: rtl/regpair_cpu_mem.sv
module regpair_cpu_mem #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/regpair_cpu_alu.sv
module regpair_cpu_alu #(
    parameter int W = 8,
    localparam int RW = 2 * W
) (
    input  logic [2:0]    op,
    input  logic [W-1:0]  x,
    input  logic [W-1:0]  y,
    output logic [RW-1:0] res
);
    always_comb begin
        res = {y, x};
        case (op)
            3'd0: res = RW'(x) + RW'(y);
            3'd1: res = RW'(x) - RW'(y);
            3'd2: res = RW'(x) * RW'(y);
            3'd3: res = (y == '0) ? '1 : RW'(x / y);
            3'd4: res = {y, x & y};
            3'd5: res = {y, x | y};
            3'd6: res = {y, x ^ y};
            3'd7: res = {y, ~x};
            default: res = {y, x};
        endcase
    end
endmodule

// File: rtl/regpair_cpu_branch.sv
module regpair_cpu_branch (
    input  logic [1:0]  kind,
    input  logic [7:0]  a,
    input  logic [7:0]  b,
    input  logic [15:0] c,
    input  logic [15:0] d,
    output logic        take
);
    logic [8:0] sum9;

    always_comb begin
        sum9 = {1'b0, a} + {1'b0, b};
        case (kind)
            2'd0: take = sum9[8];
            2'd1: take = (a == 8'h00);
            2'd2: take = (a == b);
            default: take = (c == d);
        endcase
    end
endmodule

// File: rtl/regpair_cpu.sv
module regpair_cpu
    import regpair_cpu_pkg::*;
#(
    parameter int MEM_DEPTH  = 256,
    parameter int NOP_CYCLES = 5,
    localparam int AW = $clog2(MEM_DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_data,
    input  logic [7:0]    in_port,
    output logic [7:0]    out_port,
    output logic          halted
);
    localparam int WCW = (NOP_CYCLES > 2) ? $clog2(NOP_CYCLES - 1) : 1;
    localparam logic [WCW-1:0] WAIT_START = WCW'(NOP_CYCLES - 2);

    typedef struct packed {
        cpu_state_e     state;
        logic [AW-1:0]  pc;
        logic [7:0]     ir;
        logic [7:0]     opa;
        logic [7:0]     opb;
        logic [7:0]     a;
        logic [7:0]     b;
        logic [15:0]    c;
        logic [15:0]    d;
        logic [7:0]     out;
        logic [WCW-1:0] wait_cnt;
        logic           halt;
    } core_t;

    core_t r_q, r_d;

    logic [AW-1:0] mem_raddr;
    logic [7:0]    mem_rdata;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [7:0]    mem_wdata;
    logic [15:0]   res8;
    logic [31:0]   res16;
    logic          jump_take;
    logic [2:0]    op8_sel;
    logic [2:0]    op16_sel;
    logic [AW-1:0] data_addr;
    logic [AW-1:0] jump_addr;

    assign data_addr = AW'({r_q.opb, r_q.opa});
    assign jump_addr = AW'({r_q.opa, r_q.opb});
    assign op8_sel   = 3'(r_q.ir - OPC_B_LO);
    assign op16_sel  = 3'(r_q.ir - OPC_W_LO);

    always_comb begin
        mem_raddr = r_q.pc;
        if (r_q.state == ST_EXEC) begin
            mem_raddr = data_addr;
        end
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = data_addr;
        mem_wdata = r_q.a;
        if (rst) begin
            mem_we    = ld_en;
            mem_waddr = ld_addr;
            mem_wdata = ld_data;
        end else if (r_q.state == ST_EXEC && r_q.ir == OPC_STR) begin
            mem_we = 1'b1;
        end
    end

    regpair_cpu_mem #(.DEPTH(MEM_DEPTH)) u_mem (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_addr (mem_waddr),
        .wr_data (mem_wdata),
        .rd_addr (mem_raddr),
        .rd_data (mem_rdata)
    );

    regpair_cpu_alu #(.W(8)) u_alu8 (
        .op  (op8_sel),
        .x   (r_q.a),
        .y   (r_q.b),
        .res (res8)
    );

    regpair_cpu_alu #(.W(16)) u_alu16 (
        .op  (op16_sel),
        .x   (r_q.c),
        .y   (r_q.d),
        .res (res16)
    );

    regpair_cpu_branch u_branch (
        .kind (r_q.ir[1:0]),
        .a    (r_q.a),
        .b    (r_q.b),
        .c    (r_q.c),
        .d    (r_q.d),
        .take (jump_take)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_FETCH: begin
                r_d.ir = mem_rdata;
                r_d.pc = r_q.pc + AW'(1);
                if (takes_operands(mem_rdata)) begin
                    r_d.state = ST_OPA;
                end else if (is_plain_op(mem_rdata)) begin
                    r_d.state = ST_EXEC;
                end else begin
                    r_d.state    = ST_WAIT;
                    r_d.wait_cnt = WAIT_START;
                end
            end
            ST_OPA: begin
                r_d.opa   = mem_rdata;
                r_d.pc    = r_q.pc + AW'(1);
                r_d.state = ST_OPB;
            end
            ST_OPB: begin
                r_d.opb   = mem_rdata;
                r_d.pc    = r_q.pc + AW'(1);
                r_d.state = ST_EXEC;
            end
            ST_EXEC: begin
                r_d.state = ST_FETCH;
                if (r_q.ir >= OPC_B_LO && r_q.ir <= OPC_B_HI) begin
                    {r_d.b, r_d.a} = res8;
                end else if (r_q.ir >= OPC_W_LO && r_q.ir <= OPC_W_HI) begin
                    {r_d.d, r_d.c} = res16;
                end else if (r_q.ir >= OPC_JC_LO && r_q.ir <= OPC_JC_HI) begin
                    if (jump_take) begin
                        r_d.pc = jump_addr;
                    end
                end else begin
                    case (r_q.ir)
                        OPC_HLT: begin
                            r_d.halt  = 1'b1;
                            r_d.state = ST_HALT;
                        end
                        OPC_LDA: r_d.a = mem_rdata;
                        OPC_LDB: r_d.b = mem_rdata;
                        OPC_A2C: r_d.c = {r_q.b, r_q.a};
                        OPC_A2D: r_d.d = {r_q.b, r_q.a};
                        OPC_C2A: {r_d.b, r_d.a} = r_q.c;
                        OPC_D2A: {r_d.b, r_d.a} = r_q.d;
                        OPC_IN:  r_d.a = in_port;
                        OPC_OUT: r_d.out = r_q.a;
                        OPC_JMP: r_d.pc = jump_addr;
                        OPC_SWB: begin
                            r_d.a = r_q.b;
                            r_d.b = r_q.a;
                        end
                        OPC_SWW: begin
                            r_d.c = r_q.d;
                            r_d.d = r_q.c;
                        end
                        default: r_d.state = ST_FETCH;
                    endcase
                end
            end
            ST_WAIT: begin
                if (r_q.wait_cnt == '0) begin
                    r_d.state = ST_FETCH;
                end else begin
                    r_d.wait_cnt = r_q.wait_cnt - WCW'(1);
                end
            end
            ST_HALT: r_d.state = ST_HALT;
            default: r_d.state = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_port = r_q.out;
    assign halted   = r_q.halt;
endmodule

// File: rtl/regpair_cpu_chk.sv
module regpair_cpu_chk
    import regpair_cpu_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          halted,
    input logic [7:0]    out_port,
    input cpu_state_e    state,
    input logic [7:0]    ir,
    input logic [AW-1:0] pc,
    input logic [7:0]    opa,
    input logic [7:0]    opb,
    input logic [7:0]    reg_a
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (out_port == 8'h00 && !halted && pc == '0));

    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(out_port)));

    // R12
    out_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && ir == OPC_OUT) |=> (out_port == $past(reg_a)));

    // R8
    jmp_target_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && ir == OPC_JMP) |=> (pc == AW'({$past(opa), $past(opb)})));

    // R9
    jcz_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && ir == 8'h1D && reg_a != 8'h00) |=> (pc == $past(pc)));

    // R10
    wait_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |=> (state == ST_WAIT || state == ST_FETCH));
endmodule

bind regpair_cpu regpair_cpu_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .halted   (halted),
    .out_port (out_port),
    .state    (r_q.state),
    .ir       (r_q.ir),
    .pc       (r_q.pc),
    .opa      (r_q.opa),
    .opb      (r_q.opb),
    .reg_a    (r_q.a)
);

// File: tb/regpair_cpu_bench.sv
`timescale 1ns/1ps
module regpair_cpu_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_en = 1'b0;
    logic [7:0] ld_addr = 8'h00;
    logic [7:0] ld_data = 8'h00;
    logic [7:0] in_port = 8'h00;
    logic [7:0] out_port;
    logic       halted;

    int checks = 0;
    int fails  = 0;

    logic [7:0] pa [128];
    logic [7:0] pd [128];
    int pn = 0;

    always #2.5 clk = ~clk;

    regpair_cpu u_regpair_cpu (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (ld_en),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .in_port  (in_port),
        .out_port (out_port),
        .halted   (halted)
    );

    task automatic put(input logic [7:0] ad, input logic [7:0] dt);
        pa[pn] = ad;
        pd[pn] = dt;
        pn++;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(output int cyc);
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < pn; i++) begin
            ld_en = 1'b1; ld_addr = pa[i]; ld_data = pd[i];
            @(negedge clk);
        end
        ld_en = 1'b0;
        rst   = 1'b0;
        pn    = 0;
        cyc   = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            cyc++;
            if (halted) break;
        end
        if (!halted) chk("R11 halt reached", 32'(halted), 32'd1);
    endtask

    function automatic logic [15:0] exp8(input int op, input logic [7:0] a, input logic [7:0] b);
        case (op)
            0: return 16'(a) + 16'(b);
            1: return 16'(a) - 16'(b);
            2: return 16'(a) * 16'(b);
            3: return (b == 0) ? 16'hFFFF : 16'(a / b);
            4: return {b, a & b};
            5: return {b, a | b};
            6: return {b, a ^ b};
            default: return {b, ~a};
        endcase
    endfunction

    function automatic logic [31:0] exp16(input int op, input logic [15:0] c, input logic [15:0] d);
        case (op)
            0: return 32'(c) + 32'(d);
            1: return 32'(c) - 32'(d);
            2: return 32'(c) * 32'(d);
            3: return (d == 0) ? 32'hFFFFFFFF : 32'(c / d);
            4: return {d, c & d};
            5: return {d, c | d};
            6: return {d, c ^ d};
            default: return {d, ~c};
        endcase
    endfunction

    logic [7:0]  vals8  [8] = '{8'h00, 8'h01, 8'h02, 8'h07, 8'h7F, 8'h80, 8'hFE, 8'hFF};
    logic [15:0] vals16 [6] = '{16'h0000, 16'h0001, 16'h00FF, 16'h1234, 16'h8000, 16'hFFFF};

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        logic [15:0] e8;
        logic [31:0] e16;
        bit taken;
        @(negedge clk);

        // R1: leave state behind, then check cleared outputs while loading
        put(8'h00, 8'h19); put(8'h01, 8'h1A); put(8'h02, 8'h04); put(8'h03, 8'h05); put(8'h04, 8'h01);
        in_port = 8'h77;
        run(cyc);
        chk("R12 IN/OUT before reset", 32'(out_port), 32'h77);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 out_port cleared", 32'(out_port), 32'h00);
        chk("R1 halted cleared", 32'(halted), 32'h0);
        put(8'h00, 8'h1A); put(8'h01, 8'h01);
        run(cyc);
        chk("R1 A cleared", 32'(out_port), 32'h00);
        put(8'h00, 8'h06); put(8'h01, 8'h20); put(8'h02, 8'h1A); put(8'h03, 8'h01);
        run(cyc);
        chk("R1 C cleared", 32'(out_port), 32'h00);
        put(8'h00, 8'h07); put(8'h01, 8'h1A); put(8'h02, 8'h01);
        run(cyc);
        chk("R1 D cleared", 32'(out_port), 32'h00);

        // R10: cycle costs
        put(8'h00, 8'h01); run(cyc); chk("R10 HLT alone cycles", 32'(cyc), 32'd2);
        put(8'h00, 8'h00); put(8'h01, 8'h01); run(cyc); chk("R10 NOP cycles", 32'(cyc), 32'd7);
        put(8'h00, 8'h3F); put(8'h01, 8'h01); run(cyc); chk("R10 undefined opcode cycles", 32'(cyc), 32'd7);
        put(8'h00, 8'h00); put(8'h01, 8'h00); put(8'h02, 8'h01); run(cyc); chk("R10 two NOP cycles", 32'(cyc), 32'd12);
        put(8'h00, 8'h02); put(8'h01, 8'hF0); put(8'h02, 8'h00); put(8'h03, 8'h01); put(8'hF0, 8'h00);
        run(cyc); chk("R10 operand opcode cycles", 32'(cyc), 32'd6);
        put(8'h00, 8'h19); put(8'h01, 8'h01); run(cyc); chk("R10 plain opcode cycles", 32'(cyc), 32'd4);

        // R11: nothing after HLT executes
        put(8'h00, 8'h02); put(8'h01, 8'hF0); put(8'h02, 8'h00); put(8'h03, 8'h1A); put(8'h04, 8'h01);
        put(8'h05, 8'h02); put(8'h06, 8'hF1); put(8'h07, 8'h00); put(8'h08, 8'h1A); put(8'h09, 8'h01);
        put(8'hF0, 8'hA5); put(8'hF1, 8'h3C);
        run(cyc);
        repeat (20) @(negedge clk);
        chk("R11 out held after halt", 32'(out_port), 32'hA5);
        chk("R11 halted held", 32'(halted), 32'h1);

        // R12: exhaustive input port copy
        for (int v = 0; v < 256; v++) begin
            in_port = 8'(v);
            put(8'h00, 8'h19); put(8'h01, 8'h1A); put(8'h02, 8'h01);
            run(cyc);
            chk("R12 IN then OUT", 32'(out_port), 32'(v));
        end

        // R2 / R13: store and reload with ignored upper address bits
        for (int v = 0; v < 8; v++) begin
            put(8'h00, 8'h02); put(8'h01, 8'hF0); put(8'h02, 8'h00);
            put(8'h03, 8'h08); put(8'h04, 8'hF8); put(8'h05, 8'h7A);
            put(8'h06, 8'h02); put(8'h07, 8'hF1); put(8'h08, 8'h00);
            put(8'h09, 8'h02); put(8'h0A, 8'hF8); put(8'h0B, 8'h33);
            put(8'h0C, 8'h1A); put(8'h0D, 8'h01);
            put(8'hF0, vals8[v] ^ 8'h5C); put(8'hF1, 8'h99);
            run(cyc);
            chk("R2 R13 store then load", 32'(out_port), 32'(vals8[v] ^ 8'h5C));
        end

        // R13 / R8 / R9: JMP into top of memory, wrap to 0
        in_port = 8'h5C;
        put(8'h00, 8'h1D); put(8'h01, 8'h00); put(8'h02, 8'h10);
        put(8'h03, 8'h1A); put(8'h04, 8'h01);
        put(8'h10, 8'h19); put(8'h11, 8'h1B); put(8'h12, 8'h00); put(8'h13, 8'hFE);
        put(8'hFE, 8'h20); put(8'hFF, 8'h20);
        run(cyc);
        chk("R13 R8 pc wrap after JMP", 32'(out_port), 32'h5C);

        // R3 R4 R7: byte operations over the value grid
        for (int op = 0; op < 8; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    e8 = exp8(op, vals8[i], vals8[j]);
                    for (int h = 0; h < 2; h++) begin
                        put(8'h00, 8'h02); put(8'h01, 8'hF0); put(8'h02, 8'h5A);
                        put(8'h03, 8'h03); put(8'h04, 8'hF1); put(8'h05, 8'h00);
                        put(8'h06, 8'(8'h09 + op));
                        if (h == 1) begin
                            put(8'h07, 8'h20); put(8'h08, 8'h1A); put(8'h09, 8'h01);
                        end else begin
                            put(8'h07, 8'h1A); put(8'h08, 8'h01);
                        end
                        put(8'hF0, vals8[i]); put(8'hF1, vals8[j]);
                        run(cyc);
                        chk((op < 4) ? "R3 R7 byte arith result" : "R4 byte logic result",
                            32'(out_port), 32'(h ? e8[15:8] : e8[7:0]));
                    end
                end
            end
        end

        // R5 R6 R7: word operations, every result byte via transfers
        for (int op = 0; op < 8; op++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    e16 = exp16(op, vals16[i], vals16[j]);
                    for (int k = 0; k < 4; k++) begin
                        put(8'h00, 8'h02); put(8'h01, 8'hF0); put(8'h02, 8'h00);
                        put(8'h03, 8'h03); put(8'h04, 8'hF1); put(8'h05, 8'h00);
                        put(8'h06, 8'h04);
                        put(8'h07, 8'h02); put(8'h08, 8'hF2); put(8'h09, 8'h00);
                        put(8'h0A, 8'h03); put(8'h0B, 8'hF3); put(8'h0C, 8'h00);
                        put(8'h0D, 8'h05);
                        put(8'h0E, 8'(8'h11 + op));
                        put(8'h0F, (k < 2) ? 8'h06 : 8'h07);
                        if (k % 2 == 1) begin
                            put(8'h10, 8'h20); put(8'h11, 8'h1A); put(8'h12, 8'h01);
                        end else begin
                            put(8'h10, 8'h1A); put(8'h11, 8'h01);
                        end
                        put(8'hF0, vals16[i][7:0]); put(8'hF1, vals16[i][15:8]);
                        put(8'hF2, vals16[j][7:0]); put(8'hF3, vals16[j][15:8]);
                        run(cyc);
                        chk((op < 4) ? "R5 R6 R7 word arith byte" : "R5 R6 word logic byte",
                            32'(out_port), 32'((e16 >> (8 * k)) & 32'hFF));
                    end
                end
            end
        end

        // R6: word swap
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                put(8'h00, 8'h02); put(8'h01, 8'hF0); put(8'h02, 8'h00);
                put(8'h03, 8'h03); put(8'h04, 8'hF1); put(8'h05, 8'h00);
                put(8'h06, 8'h04);
                put(8'h07, 8'h02); put(8'h08, 8'hF2); put(8'h09, 8'h00);
                put(8'h0A, 8'h03); put(8'h0B, 8'hF3); put(8'h0C, 8'h00);
                put(8'h0D, 8'h05); put(8'h0E, 8'h21); put(8'h0F, 8'h06);
                put(8'h10, 8'h20); put(8'h11, 8'h1A); put(8'h12, 8'h01);
                put(8'hF0, vals16[i][7:0]); put(8'hF1, vals16[i][15:8]);
                put(8'hF2, vals16[j][7:0]); put(8'hF3, vals16[j][15:8]);
                run(cyc);
                chk("R6 word swap", 32'(out_port), 32'(vals16[j][15:8]));
            end
        end

        // R9: conditional jumps, taken marker 0x22, fall-through marker 0x11
        for (int jk = 0; jk < 4; jk++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    case (jk)
                        0: taken = (int'(vals8[i]) + int'(vals8[j])) > 255;
                        1: taken = (vals8[i] == 8'h00);
                        default: taken = (vals8[i] == vals8[j]);
                    endcase
                    put(8'h00, 8'h02); put(8'h01, 8'hF0); put(8'h02, 8'h00);
                    put(8'h03, 8'h03); put(8'h04, 8'hF1); put(8'h05, 8'h00);
                    if (jk == 3) begin
                        put(8'h06, 8'h04); put(8'h07, 8'h20); put(8'h08, 8'h05);
                        put(8'h09, 8'h1F); put(8'h0A, 8'h00); put(8'h0B, 8'h20);
                        put(8'h0C, 8'h02); put(8'h0D, 8'hF2); put(8'h0E, 8'h00);
                        put(8'h0F, 8'h1A); put(8'h10, 8'h01);
                    end else begin
                        put(8'h06, 8'(8'h1C + jk)); put(8'h07, 8'h00); put(8'h08, 8'h20);
                        put(8'h09, 8'h02); put(8'h0A, 8'hF2); put(8'h0B, 8'h00);
                        put(8'h0C, 8'h1A); put(8'h0D, 8'h01);
                    end
                    put(8'h20, 8'h02); put(8'h21, 8'hF3); put(8'h22, 8'h00);
                    put(8'h23, 8'h1A); put(8'h24, 8'h01);
                    put(8'hF0, vals8[i]); put(8'hF1, vals8[j]);
                    put(8'hF2, 8'h11); put(8'hF3, 8'h22);
                    run(cyc);
                    chk("R9 R8 conditional jump", 32'(out_port), taken ? 32'h22 : 32'h11);
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule